// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator

This block holds two 40-bit signed accumulators, A and B, which share a single 41-bit adder/subtractor. Each operation names one accumulator. That accumulator is the left operand and also receives the result. The right operand can be a 32-bit product, a 16-bit data word shifted left by a programmable amount, or the other accumulator. Narrower operands are sign-extended before the adder sees them. Eight guard bits sit above a 32-bit working range, so sums can grow past 32 bits without losing information.

Every operation reports two overflow classes for the accumulator it writes. The guard flag shows that the guard bits no longer agree. The catastrophic flag shows that the true result no longer fits in 40 bits. The guard flag follows the most recent result. The catastrophic flag is sticky until it is cleared. When saturation is enabled, the written value is clamped to either a 32-bit or a 40-bit limit. A one-cycle trap pulse can be raised for either overflow class.

All results, flags and the trap are registered. They appear on the clock edge that samples the operation.

Top module: `acc_pair_sat`

## Requirements
- R1: While reset is low, both accumulators, all four flags and trap are zero.
- R2: An edge where op_valid is 0, or where op_code is 7 (idle), leaves both accumulators and both guard flags unchanged, and trap is 0 after that edge.
- R3: An operation changes only the accumulator chosen by acc_sel (0 = A, 1 = B) and only that accumulator's flags (flag bit 0 = A, bit 1 = B). The other accumulator is never modified.
- R4: op_code 0 adds the sign-extended 32-bit prod_in to the selected accumulator. op_code 1 subtracts it.
- R5: op_code 2 adds the data word, and op_code 3 loads the data word. The data word is data_in sign-extended to 40 bits and then shifted left by shift_amt (0 to 15).
- R6: op_code 4 adds the other accumulator to the selected one. op_code 5 subtracts the other accumulator from the selected one. op_code 6 replaces the selected accumulator with its own negation.
- R7: Every operation sets the guard flag of its accumulator when bits 39..32 of the unsaturated 40-bit result are not all equal, and clears that flag otherwise.
- R8: The catastrophic flag of an accumulator is set when the true result lies outside the signed 40-bit range. It stays set until the matching clr_cat bit is high at an edge. If a set and a clear happen on the same edge, the set wins.
- R9: With sat_en=1 and sat32=0, a result with catastrophic overflow is written as 0x7FFFFFFFFF when the true result is positive, and as 0x8000000000 when it is negative.
- R10: With sat_en=1 and sat32=1, a result above 2^31-1 is written as 0x007FFFFFFF. A result below -2^31 is written as 0xFF80000000.
- R11: trap is high for exactly the cycle after an operation whose catastrophic flag condition met trap_en_cat=1, or whose guard flag condition met trap_en_grd=1.
- R12: With sat_en=0, the result wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code, 0..7 (see R4-R6, 7 = idle) |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| prod_in | input | 32 | Signed product operand |
| data_in | input | 16 | Signed data operand |
| shift_amt | input | 4 | Left shift applied to data_in |
| sat_en | input | 1 | Saturation enable |
| sat32 | input | 1 | 1 = 32-bit limit, 0 = 40-bit limit |
| trap_en_cat | input | 1 | Trap on catastrophic overflow |
| trap_en_grd | input | 1 | Trap on guard-bit overflow |
| clr_cat | input | 2 | Clear sticky catastrophic flag (bit 0 = A, bit 1 = B) |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_grd | output | 2 | Guard-bit overflow flags |
| ovf_cat | output | 2 | Sticky catastrophic overflow flags |
| trap | output | 1 | One-cycle arithmetic trap pulse |

## Verification
Every accumulator and flag is a port, so a wrong internal value shows up directly on acc_a, acc_b, ovf_grd or ovf_cat on the edge that follows the faulty operation. A fault in operand selection or in sign extension corrupts the written accumulator on that same edge. A fault in the saturation or flag logic shows up as a wrong clamp value, a missing flag or a missing trap pulse on that same edge. A sticky flag that leaks away is caught on the next idle or unrelated cycle, because the flag is compared at every step.

// File: rtl/acc40_pkg.sv
// Package: shared operation codes for the dual accumulator.
// Assumes: codes are 3 bits wide; code 7 is the idle code.
package acc40_pkg;
    typedef enum logic [2:0] {
        OP_ADD_PROD  = 3'd0,
        OP_SUB_PROD  = 3'd1,
        OP_ADD_DATA  = 3'd2,
        OP_LOAD_DATA = 3'd3,
        OP_ADD_OTHER = 3'd4,
        OP_SUB_OTHER = 3'd5,
        OP_NEGATE    = 3'd6,
        OP_IDLE      = 3'd7
    } acc_op_e;
endpackage

// File: rtl/acc_operand_mux.sv
// Operand selection: builds the left and right adder operands and the
// subtract control from the op code.
// Assumes: DATA_W + 2**SH_W - 1 <= ACC_W, so the shifted data keeps its sign.
module acc_operand_mux
    import acc40_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int PROD_W = 32,
    parameter int DATA_W = 16,
    parameter int SH_W   = 4
) (
    input  logic [2:0]        op,
    input  logic [ACC_W-1:0]  self_acc,
    input  logic [ACC_W-1:0]  other_acc,
    input  logic [PROD_W-1:0] prod,
    input  logic [DATA_W-1:0] data,
    input  logic [SH_W-1:0]   shamt,
    output logic [ACC_W-1:0]  lhs,
    output logic [ACC_W-1:0]  rhs,
    output logic              do_sub
);
    localparam int PROD_PAD = ACC_W - PROD_W;
    localparam int DATA_PAD = ACC_W - DATA_W;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] data_ext;
    logic [ACC_W-1:0] data_sh;

    // Sign-extend the narrow operands and apply the data shift.
    always_comb begin
        prod_ext = {{PROD_PAD{prod[PROD_W-1]}}, prod};
        data_ext = {{DATA_PAD{data[DATA_W-1]}}, data};
        data_sh  = data_ext << shamt;
    end

    // Route operands according to the operation.
    always_comb begin
        lhs    = self_acc;
        rhs    = '0;
        do_sub = 1'b0;
        case (acc_op_e'(op))
            OP_ADD_PROD:  rhs = prod_ext;
            OP_SUB_PROD:  begin rhs = prod_ext; do_sub = 1'b1; end
            OP_ADD_DATA:  rhs = data_sh;
            OP_LOAD_DATA: begin lhs = '0; rhs = data_sh; end
            OP_ADD_OTHER: rhs = other_acc;
            OP_SUB_OTHER: begin rhs = other_acc; do_sub = 1'b1; end
            OP_NEGATE:    begin lhs = '0; rhs = self_acc; do_sub = 1'b1; end
            default:      rhs = '0;
        endcase
    end
endmodule

// File: rtl/acc_addsub.sv
// Shared adder/subtractor: forms the exact (ACC_W+1)-bit signed result and
// derives the guard and catastrophic overflow conditions from it.
// Assumes: operands are two's complement of ACC_W bits.
module acc_addsub #(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8
) (
    input  logic [ACC_W-1:0] lhs,
    input  logic [ACC_W-1:0] rhs,
    input  logic             do_sub,
    output logic [ACC_W:0]   sum,
    output logic             cat,
    output logic             grd
);
    logic [ACC_W:0]     a_x;
    logic [ACC_W:0]     b_x;
    logic [GUARD_W-1:0] guard_bits;

    // Exact sum in one extra bit, so no information is lost.
    always_comb begin
        a_x = {lhs[ACC_W-1], lhs};
        b_x = {rhs[ACC_W-1], rhs};
        sum = do_sub ? (a_x - b_x) : (a_x + b_x);
    end

    // Overflow classes: past the top bit, and disagreeing guard bits.
    always_comb begin
        guard_bits = sum[ACC_W-1 -: GUARD_W];
        cat        = sum[ACC_W] ^ sum[ACC_W-1];
        grd        = !((&guard_bits) || !(|guard_bits));
    end
endmodule

// File: rtl/acc_saturate.sv
// Saturation: clamps the exact result to the full or the low-word signed
// range, or wraps it when saturation is off.
// Assumes: LOW_W < ACC_W.
module acc_saturate #(
    parameter int ACC_W = 40,
    parameter int LOW_W = 32
) (
    input  logic [ACC_W:0]   sum,
    input  logic             sat_en,
    input  logic             sat32,
    output logic [ACC_W-1:0] res
);
    localparam int HI_W = ACC_W - LOW_W + 1;
    localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MAX_LOW  = {{HI_W{1'b0}}, {(LOW_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_LOW  = {{HI_W{1'b1}}, {(LOW_W-1){1'b0}}};

    logic [ACC_W-LOW_W+1:0] top_bits;
    logic fits_low;
    logic fits_full;
    logic is_neg;

    // Range tests on the exact result.
    always_comb begin
        top_bits  = sum[ACC_W:LOW_W-1];
        fits_low  = (&top_bits) || !(|top_bits);
        fits_full = sum[ACC_W] == sum[ACC_W-1];
        is_neg    = sum[ACC_W];
    end

    // Pick the clamp value or the wrapped result.
    always_comb begin
        res = sum[ACC_W-1:0];
        if (sat_en && sat32 && !fits_low)
            res = is_neg ? MIN_LOW : MAX_LOW;
        else if (sat_en && !sat32 && !fits_full)
            res = is_neg ? MIN_FULL : MAX_FULL;
    end
endmodule

// File: rtl/acc_slot.sv
// One accumulator slot: holds the value, the live guard flag and the
// sticky catastrophic flag.
// Assumes: wr_en is high only for an operation aimed at this slot.
module acc_slot #(
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_val,
    input  logic             grd_in,
    input  logic             cat_in,
    input  logic             clr,
    output logic [ACC_W-1:0] q,
    output logic             grd,
    output logic             cat
);
    // Value and guard flag follow each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            grd <= 1'b0;
        end else if (wr_en) begin
            q   <= wr_val;
            grd <= grd_in;
        end
    end

    // Sticky catastrophic flag; a new set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cat <= 1'b0;
        else        cat <= (cat & ~clr) | (wr_en & cat_in);
    end
endmodule

// File: rtl/acc_pair_sat.sv
// Dual saturating accumulator top: one shared datapath feeds the selected
// slot; the trap pulse is registered alongside the result.
// Assumes: two accumulators; op_code 7 is idle.
module acc_pair_sat
    import acc40_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int GUARD_W = 8,
    parameter int PROD_W  = 32,
    parameter int DATA_W  = 16,
    parameter int SH_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic              acc_sel,
    input  logic [PROD_W-1:0] prod_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [SH_W-1:0]   shift_amt,
    input  logic              sat_en,
    input  logic              sat32,
    input  logic              trap_en_cat,
    input  logic              trap_en_grd,
    input  logic [1:0]        clr_cat,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic [1:0]        ovf_grd,
    output logic [1:0]        ovf_cat,
    output logic              trap
);
    localparam int N_ACC = 2;
    localparam int LOW_W = ACC_W - GUARD_W;

    logic [N_ACC-1:0][ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] self_acc;
    logic [ACC_W-1:0] other_acc;
    logic [ACC_W-1:0] lhs;
    logic [ACC_W-1:0] rhs;
    logic             do_sub;
    logic [ACC_W:0]   sum;
    logic             cat_now;
    logic             grd_now;
    logic [ACC_W-1:0] res;
    logic             op_ok;

    // Accept only real operations.
    always_comb begin
        op_ok     = op_valid && (acc_op_e'(op_code) != OP_IDLE);
        self_acc  = acc_q[acc_sel];
        other_acc = acc_q[~acc_sel];
    end

    acc_operand_mux #(
        .ACC_W(ACC_W), .PROD_W(PROD_W), .DATA_W(DATA_W), .SH_W(SH_W)
    ) u_mux (
        .op(op_code), .self_acc(self_acc), .other_acc(other_acc),
        .prod(prod_in), .data(data_in), .shamt(shift_amt),
        .lhs(lhs), .rhs(rhs), .do_sub(do_sub)
    );

    acc_addsub #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) u_add (
        .lhs(lhs), .rhs(rhs), .do_sub(do_sub),
        .sum(sum), .cat(cat_now), .grd(grd_now)
    );

    acc_saturate #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_sat (
        .sum(sum), .sat_en(sat_en), .sat32(sat32), .res(res)
    );

    for (genvar g = 0; g < N_ACC; g++) begin : g_slot
        logic hit;
        assign hit = op_ok && (acc_sel == g[0]);
        acc_slot #(.ACC_W(ACC_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_en(hit), .wr_val(res),
            .grd_in(grd_now), .cat_in(cat_now), .clr(clr_cat[g]),
            .q(acc_q[g]), .grd(ovf_grd[g]), .cat(ovf_cat[g])
        );
    end

    // One-cycle trap for an enabled overflow class.
    always_ff @(posedge clk) begin
        if (!rst_n) trap <= 1'b0;
        else        trap <= op_ok && ((cat_now && trap_en_cat) || (grd_now && trap_en_grd));
    end

    assign acc_a = acc_q[0];
    assign acc_b = acc_q[1];
endmodule

// File: rtl/acc40_checker.sv
// Checker: temporal properties of the dual accumulator, bound to the top.
// Assumes: two accumulators, flag bit 0 = A.
module acc40_checker #(
    parameter int ACC_W = 40,
    parameter int LOW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic             acc_sel,
    input logic             sat_en,
    input logic             sat32,
    input logic [1:0]       clr_cat,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b,
    input logic [1:0]       ovf_grd,
    input logic [1:0]       ovf_cat,
    input logic             trap
);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b) && $stable(ovf_grd) && !trap));

    // R3
    other_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> ($stable(acc_b) && $stable(ovf_grd[1])));

    // R3
    other_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> ($stable(acc_a) && $stable(ovf_grd[0])));

    // R8
    cat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cat[0] && !clr_cat[0]) |=> ovf_cat[0]);

    // R10
    sat_low_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel && sat_en && sat32 && op_code != 3'd7)
        |=> ((&acc_a[ACC_W-1:LOW_W-1]) || !(|acc_a[ACC_W-1:LOW_W-1])));

    // R11
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(op_valid));
endmodule

bind acc_pair_sat acc40_checker #(.ACC_W(ACC_W), .LOW_W(ACC_W - GUARD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_sel(acc_sel), .sat_en(sat_en), .sat32(sat32), .clr_cat(clr_cat),
    .acc_a(acc_a), .acc_b(acc_b), .ovf_grd(ovf_grd), .ovf_cat(ovf_cat),
    .trap(trap)
);

// File: tb/sim_acc_pair_sat.sv
`timescale 1ns/1ps
module sim_acc_pair_sat;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic        acc_sel;
    logic [31:0] prod_in;
    logic [15:0] data_in;
    logic [3:0]  shift_amt;
    logic        sat_en, sat32, trap_en_cat, trap_en_grd;
    logic [1:0]  clr_cat;
    logic [39:0] acc_a, acc_b;
    logic [1:0]  ovf_grd, ovf_cat;
    logic        trap;

    always #2.5 clk = ~clk;

    acc_pair_sat u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .prod_in(prod_in), .data_in(data_in),
        .shift_amt(shift_amt), .sat_en(sat_en), .sat32(sat32),
        .trap_en_cat(trap_en_cat), .trap_en_grd(trap_en_grd),
        .clr_cat(clr_cat), .acc_a(acc_a), .acc_b(acc_b),
        .ovf_grd(ovf_grd), .ovf_cat(ovf_cat), .trap(trap)
    );

    typedef struct {
        logic [39:0] a;
        logic [39:0] b;
        logic [1:0]  g;
        logic [1:0]  c;
        logic        t;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint m_acc[2];
    logic [1:0] m_grd = '0;
    logic [1:0] m_cat = '0;

    localparam longint MAX40 = (64'sd1 <<< 39) - 1;
    localparam longint MIN40 = -(64'sd1 <<< 39);
    localparam longint MAX32 = (64'sd1 <<< 31) - 1;
    localparam longint MIN32 = -(64'sd1 <<< 31);

    function automatic longint from40(input logic [39:0] v);
        return longint'($signed(v));
    endfunction

    // Driver: apply one cycle of stimulus, model it, push the expectation.
    task automatic apply(input bit v, input logic [2:0] c, input bit s,
                         input logic [31:0] p, input logic [15:0] d,
                         input logic [3:0] sh, input bit se, input bit s32,
                         input bit tc, input bit tg, input logic [1:0] clr,
                         input string tag);
        longint self_v, other_v, l, r, t, res;
        logic [39:0] w;
        bit sub, catf, grdf, real_op;
        exp_t e;
        @(negedge clk);
        op_valid = v; op_code = c; acc_sel = s; prod_in = p; data_in = d;
        shift_amt = sh; sat_en = se; sat32 = s32; trap_en_cat = tc;
        trap_en_grd = tg; clr_cat = clr;
        real_op = v && (c != 3'd7);
        catf = 1'b0; grdf = 1'b0;
        m_cat = m_cat & ~clr;
        if (real_op) begin
            self_v  = m_acc[s];
            other_v = m_acc[!s];
            l = self_v; r = 0; sub = 1'b0;
            case (c)
                3'd0: r = longint'($signed(p));
                3'd1: begin r = longint'($signed(p)); sub = 1'b1; end
                3'd2: r = longint'($signed(d)) <<< sh;
                3'd3: begin l = 0; r = longint'($signed(d)) <<< sh; end
                3'd4: r = other_v;
                3'd5: begin r = other_v; sub = 1'b1; end
                default: begin l = 0; r = self_v; sub = 1'b1; end
            endcase
            t = sub ? l - r : l + r;
            catf = (t > MAX40) || (t < MIN40);
            w = t[39:0];
            grdf = (w[39:32] != 8'h00) && (w[39:32] != 8'hFF);
            res = from40(w);
            if (se && s32) begin
                if (t > MAX32) res = MAX32;
                else if (t < MIN32) res = MIN32;
            end else if (se && catf) begin
                res = (t > 0) ? MAX40 : MIN40;
            end
            m_acc[s] = res;
            m_grd[s] = grdf;
            if (catf) m_cat[s] = 1'b1;
        end
        @(posedge clk);
        #1;
        e.a = m_acc[0][39:0]; e.b = m_acc[1][39:0];
        e.g = m_grd; e.c = m_cat;
        e.t = real_op && ((catf && tc) || (grdf && tg));
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare the outputs with the next expected item.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if ({acc_a, acc_b, ovf_grd, ovf_cat, trap} !== {e.a, e.b, e.g, e.c, e.t}) begin
                fails++;
                $display("FAIL %s: got a=%h b=%h grd=%b cat=%b trap=%b exp a=%h b=%h grd=%b cat=%b trap=%b",
                         e.tag, acc_a, acc_b, ovf_grd, ovf_cat, trap,
                         e.a, e.b, e.g, e.c, e.t);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_acc[0] = 0; m_acc[1] = 0;
        rst_n = 1'b0; op_valid = 0; op_code = 0; acc_sel = 0; prod_in = 0;
        data_in = 0; shift_amt = 0; sat_en = 0; sat32 = 0;
        trap_en_cat = 0; trap_en_grd = 0; clr_cat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({acc_a, acc_b, ovf_grd, ovf_cat, trap} !== '0) begin
            fails++;
            $display("FAIL R1: got a=%h b=%h grd=%b cat=%b trap=%b exp all zero",
                     acc_a, acc_b, ovf_grd, ovf_cat, trap);
        end
        rst_n = 1'b1;

        apply(1, 3, 0, 0, 16'h1234, 4, 0, 0, 0, 0, 0, "R5 load");
        apply(1, 0, 0, 32'h0001_0000, 0, 0, 0, 0, 0, 0, 0, "R4 add prod");
        apply(1, 1, 1, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, "R4 sub prod");
        apply(1, 2, 1, 0, 16'hFFFF, 15, 0, 0, 0, 0, 0, "R5 add shifted");
        apply(1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 add other");
        apply(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 sub other");
        apply(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 negate");
        apply(0, 0, 0, 32'h7FFF_FFFF, 16'h7FFF, 15, 0, 0, 1, 1, 0, "R2 no valid");
        apply(1, 7, 1, 32'h7FFF_FFFF, 16'h7FFF, 15, 0, 0, 1, 1, 0, "R2 idle code");

        apply(1, 3, 0, 0, 16'h7FFF, 15, 0, 0, 0, 1, 0, "R3 load A");
        apply(1, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 1, 0, "R7 no guard yet");
        apply(1, 0, 0, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 1, 0, "R7 R11 guard trap");
        apply(1, 3, 0, 0, 16'h0005, 0, 0, 0, 0, 0, 0, "R7 guard clears");

        apply(1, 3, 0, 0, 16'h4000, 15, 0, 0, 0, 0, 0, "R5 seed A");
        apply(1, 3, 1, 0, 16'h4000, 15, 0, 0, 0, 0, 0, "R5 seed B");
        for (int k = 0; k < 40 && m_cat == 2'b00; k++)
            apply(1, 4, k[0], 0, 0, 0, 0, 0, 0, 0, 0, "R12 R8 wrap growth");
        apply(1, 3, 0, 0, 16'h0001, 0, 0, 0, 0, 0, 0, "R8 sticky");
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b11, "R8 clear");

        apply(1, 3, 0, 0, 16'h4000, 15, 0, 0, 0, 0, 0, "R9 seed A");
        apply(1, 3, 1, 0, 16'h4000, 15, 0, 0, 0, 0, 0, "R9 seed B");
        for (int k = 0; k < 40 && m_cat == 2'b00; k++)
            apply(1, 4, k[0], 0, 0, 0, 1, 0, 1, 0, 2'b11, "R9 R11 R8 sat40");

        apply(1, 3, 0, 0, 16'h7FFF, 15, 1, 1, 0, 0, 2'b11, "R10 seed");
        apply(1, 0, 0, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 0, 0, "R10 clamp high");
        apply(1, 0, 0, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 0, 0, "R10 stay high");
        apply(1, 3, 1, 0, 16'h8000, 15, 1, 1, 0, 0, 0, "R10 seed neg");
        apply(1, 1, 1, 32'h7FFF_FFFF, 0, 0, 1, 1, 0, 0, 0, "R10 clamp low");
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 trap drops");

        wait (exp_q.size() == 0);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule